// File: doc/BRIEF.md
# Physical Address Cacheability Checker

This block sits after address translation and judges a physical address before it reaches the memory system. It takes the address, a flag that says whether the access is an instruction fetch, and a flag that says whether the address came from a kernel direct-mapped window (a superpage) rather than a page-table entry. It returns the final physical address, a flag that marks the access as uncacheable, and a two-bit fault code.

Direct-mapped addresses are first sign-extended from bit 40 into the top of the 44-bit implemented range. The address is then checked for stray bits above the implemented width. Bit 43 selects the uncacheable I/O space. Uncacheable addresses have an eight-bit field folded away. Addresses in the internal register window are refused. Instruction fetches from uncacheable space are refused too. All outputs are combinational, so the block can be dropped into the same cycle as the translation result.

Top module: `pa_cache_check`

## Requirements
- R1: With `sp_map` low, any set bit of `in_pa` at position 44 or above gives `fault` = 1 (machine check).
- R2: A machine check takes priority over every other fault; with it, `uncached` is 0 and `out_pa` equals `in_pa`.
- R3: An address with bit 43 set and bits 43:36 not all ones gives `uncached` = 1, with `out_pa` equal to the address with bits 42:35 forced to 0 and every other bit kept.
- R4: An address with bits 43:36 all ones (the register window) gives `fault` = 2 (unimplemented), whether or not it is a fetch; `uncached` is 0 and the address is passed on unchanged.
- R5: An uncacheable address on a fetch (`is_fetch` = 1) gives `fault` = 3, while `uncached` stays 1 and the address is still rewritten as in R3.
- R6: An address with bit 43 clear and nothing above bit 43 gives `fault` = 0, `uncached` = 0 and `out_pa` equal to `in_pa`.
- R7: With `sp_map` high and bit 40 set, bits 43:40 become 1 and bits 63:44 become 0; the result then goes through the checks of R3 to R5.
- R8: With `sp_map` high and bit 40 clear, `out_pa` keeps only bits 39:0 of `in_pa`, with no fault and `uncached` 0.
- R9: With `sp_map` high, no bit of `in_pa` above 43 can cause a machine check.
- R10: `is_fetch` has no effect on the outputs for a cacheable address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_pa | input | 64 | Physical address from translation |
| is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| sp_map | input | 1 | 1 when the address comes from the direct-mapped kernel window |
| out_pa | output | 64 | Final physical address |
| uncached | output | 1 | 1 when the access must bypass the caches |
| fault | output | 2 | 0 none, 1 machine check, 2 unimplemented, 3 fetch from uncacheable space |

## Verification
Superpage sign extension and the uncacheable rewrite can act on the same address. This happens when a direct-mapped address with bit 40 set is widened into bit 43. Vectors with `sp_map` high drive such addresses, both with bits 39:36 mixed and with them all ones, on fetch and on data paths. The bench compares the address, the flag and the fault code against values worked out by hand: the extended address must be cleared in bits 42:35, or must fall into the register window and be refused. A second overlap is the set of fault sources, where a stray high bit, a register-window address and a fetch occur together and only the highest-priority code may appear.

// File: rtl/pa_chk_pkg.sv
package pa_chk_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_MCHK   = 2'd1,
        FLT_UNIMP  = 2'd2,
        FLT_IFETCH = 2'd3
    } fault_e;

endpackage

// File: rtl/pa_superpage_ext.sv
module pa_superpage_ext #(
    parameter int ADDR_W = 64,
    parameter int IMPL_W = 44,
    parameter int SX_BIT = 40
) (
    input  logic [ADDR_W-1:0] raw_pa,
    input  logic              sp_en,
    output logic [ADDR_W-1:0] staged_pa
);
    logic [ADDR_W-1:0] ext_pa;

    // Bits below SX_BIT pass, bits SX_BIT..IMPL_W-1 copy SX_BIT, above drop
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            if (i >= IMPL_W)
                ext_pa[i] = 1'b0;
            else if (i >= SX_BIT)
                ext_pa[i] = raw_pa[SX_BIT];
            else
                ext_pa[i] = raw_pa[i];
        end
    end

    assign staged_pa = sp_en ? ext_pa : raw_pa;

endmodule

// File: rtl/pa_range_chk.sv
module pa_range_chk #(
    parameter int ADDR_W = 64,
    parameter int IMPL_W = 44
) (
    input  logic [ADDR_W-1:0] pa,
    output logic              out_of_range
);
    generate
        if (ADDR_W > IMPL_W) begin : g_upper
            assign out_of_range = |pa[ADDR_W-1:IMPL_W];
        end else begin : g_none
            assign out_of_range = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pa_uncache_dec.sv
module pa_uncache_dec #(
    parameter int ADDR_W = 64,
    parameter int UC_BIT = 43,
    parameter int CLR_HI = 42,
    parameter int CLR_LO = 35,
    parameter int REG_HI = 43,
    parameter int REG_LO = 36,
    parameter logic [REG_HI-REG_LO:0] REG_PAT = '1
) (
    input  logic [ADDR_W-1:0] pa,
    output logic              uc_hit,
    output logic              reg_hit,
    output logic [ADDR_W-1:0] folded_pa
);
    assign uc_hit  = pa[UC_BIT];
    assign reg_hit = (pa[REG_HI:REG_LO] == REG_PAT);

    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            if (i >= CLR_LO && i <= CLR_HI)
                folded_pa[i] = 1'b0;
            else
                folded_pa[i] = pa[i];
        end
    end

endmodule

// File: rtl/pa_cache_check.sv
module pa_cache_check
    import pa_chk_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IMPL_W = 44,
    parameter int SX_BIT = 40,
    parameter int CLR_W  = 8,
    parameter int REG_W  = 8,
    parameter logic [REG_W-1:0] REG_PAT = '1
) (
    input  logic [ADDR_W-1:0] in_pa,
    input  logic              is_fetch,
    input  logic              sp_map,
    output logic [ADDR_W-1:0] out_pa,
    output logic              uncached,
    output logic [1:0]        fault
);
    localparam int UC_BIT = IMPL_W - 1;
    localparam int CLR_HI = UC_BIT - 1;
    localparam int CLR_LO = CLR_HI - CLR_W + 1;
    localparam int REG_HI = UC_BIT;
    localparam int REG_LO = REG_HI - REG_W + 1;

    logic [ADDR_W-1:0] staged_pa;
    logic [ADDR_W-1:0] folded_pa;
    logic              oor;
    logic              uc_hit;
    logic              reg_hit;
    logic              mchk;
    logic              in_reg;
    fault_e            flt;

    pa_superpage_ext #(.ADDR_W(ADDR_W), .IMPL_W(IMPL_W), .SX_BIT(SX_BIT)) u_ext (
        .raw_pa    (in_pa),
        .sp_en     (sp_map),
        .staged_pa (staged_pa)
    );

    pa_range_chk #(.ADDR_W(ADDR_W), .IMPL_W(IMPL_W)) u_range (
        .pa           (staged_pa),
        .out_of_range (oor)
    );

    pa_uncache_dec #(
        .ADDR_W (ADDR_W), .UC_BIT (UC_BIT), .CLR_HI (CLR_HI), .CLR_LO (CLR_LO),
        .REG_HI (REG_HI), .REG_LO (REG_LO), .REG_PAT(REG_PAT)
    ) u_dec (
        .pa        (staged_pa),
        .uc_hit    (uc_hit),
        .reg_hit   (reg_hit),
        .folded_pa (folded_pa)
    );

    assign mchk   = oor;
    assign in_reg = uc_hit && reg_hit;

    // Fault priority: range, then register window, then fetch from I/O
    always_comb begin
        if (mchk)
            flt = FLT_MCHK;
        else if (in_reg)
            flt = FLT_UNIMP;
        else if (uc_hit && is_fetch)
            flt = FLT_IFETCH;
        else
            flt = FLT_NONE;
    end

    always_comb begin
        uncached = !mchk && uc_hit && !in_reg;
        out_pa   = uncached ? folded_pa : staged_pa;
        fault    = flt;
    end

    always_comb begin
        // R2
        mchk_excl_chk: assert (!(fault == FLT_MCHK && (uncached || out_pa != in_pa)));
        // R4
        unimp_cached_chk: assert (!(fault == FLT_UNIMP && uncached));
        // R5
        ifetch_src_chk: assert (!(fault == FLT_IFETCH && !(uncached && is_fetch)));
        // R3
        fold_field_chk: assert (!(uncached && out_pa[CLR_HI:CLR_LO] != '0));
        // R9
        sp_no_mchk_chk: assert (!(sp_map && fault == FLT_MCHK));
        // R8
        sp_trunc_chk: assert (!(sp_map && !in_pa[SX_BIT] && out_pa[ADDR_W-1:SX_BIT] != '0));
    end

endmodule

// File: tb/test_pa_cache_check.sv
module test_pa_cache_check;

    typedef struct packed {
        logic [63:0] pa;
        logic        fe;
        logic        sp;
        logic [63:0] epa;
        logic        eunc;
        logic [1:0]  ef;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{64'h0000_0000_1234_5678, 1'b0, 1'b0, 64'h0000_0000_1234_5678, 1'b0, 2'd0}, // R6
        '{64'h0000_0000_1234_5678, 1'b1, 1'b0, 64'h0000_0000_1234_5678, 1'b0, 2'd0}, // R10
        '{64'h0000_1000_0000_0000, 1'b0, 1'b0, 64'h0000_1000_0000_0000, 1'b0, 2'd1}, // R1
        '{64'h8000_0000_0000_0000, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 2'd1}, // R1
        '{64'h0000_0800_0000_0000, 1'b0, 1'b0, 64'h0000_0800_0000_0000, 1'b1, 2'd0}, // R3
        '{64'h0000_0A5A_0000_1ABC, 1'b0, 1'b0, 64'h0000_0802_0000_1ABC, 1'b1, 2'd0}, // R3
        '{64'h0000_0A5A_0000_1ABC, 1'b1, 1'b0, 64'h0000_0802_0000_1ABC, 1'b1, 2'd3}, // R5
        '{64'h0000_0FF0_0000_0040, 1'b0, 1'b0, 64'h0000_0FF0_0000_0040, 1'b0, 2'd2}, // R4
        '{64'h0000_0FF0_0000_0040, 1'b1, 1'b0, 64'h0000_0FF0_0000_0040, 1'b0, 2'd2}, // R4
        '{64'h0000_1FF0_0000_0040, 1'b1, 1'b0, 64'h0000_1FF0_0000_0040, 1'b0, 2'd1}, // R2
        '{64'hFFFF_F901_2345_6789, 1'b0, 1'b1, 64'h0000_0801_2345_6789, 1'b1, 2'd0}, // R7
        '{64'hFFFF_F601_2345_6789, 1'b0, 1'b1, 64'h0000_0001_2345_6789, 1'b0, 2'd0}, // R8
        '{64'h0000_01F0_0000_0000, 1'b1, 1'b1, 64'h0000_0FF0_0000_0000, 1'b0, 2'd2}, // R7
        '{64'h0000_0100_0000_0000, 1'b1, 1'b1, 64'h0000_0800_0000_0000, 1'b1, 2'd3}  // R7
    };

    function automatic string vec_tag(int k);
        case (k)
            0:       return "R6";
            1:       return "R10";
            2, 3:    return "R1";
            4, 5:    return "R3";
            6:       return "R5";
            7, 8:    return "R4";
            9:       return "R2";
            11:      return "R8";
            default: return "R7";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic [63:0] in_pa = '0;
    logic        is_fetch = 1'b0;
    logic        sp_map = 1'b0;
    logic [63:0] out_pa;
    logic        uncached;
    logic [1:0]  fault;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pa_cache_check i_pa_cache_check (
        .in_pa    (in_pa),
        .is_fetch (is_fetch),
        .sp_map   (sp_map),
        .out_pa   (out_pa),
        .uncached (uncached),
        .fault    (fault)
    );

    task automatic apply_check(input string tag, input logic [63:0] pa, input logic fe,
                               input logic sp, input logic [63:0] epa, input logic eunc,
                               input logic [1:0] ef);
        @(posedge clk);
        in_pa = pa; is_fetch = fe; sp_map = sp;
        @(negedge clk);
        n_chk++;
        if (out_pa !== epa || uncached !== eunc || fault !== ef) begin
            n_fail++;
            $display("FAIL %s: in=%h fetch=%b sp=%b got pa=%h unc=%b flt=%0d exp pa=%h unc=%b flt=%0d",
                     tag, pa, fe, sp, out_pa, uncached, fault, epa, eunc, ef);
        end
    endtask

    initial begin
        for (int k = 0; k < NV; k++)
            apply_check(vec_tag(k), VEC[k].pa, VEC[k].fe, VEC[k].sp,
                        VEC[k].epa, VEC[k].eunc, VEC[k].ef);
        // R1: each stray bit above the implemented range alone
        for (int b = 44; b < 64; b++)
            apply_check("R1", (64'd1 << b) | 64'h55, 1'b0, 1'b0,
                        (64'd1 << b) | 64'h55, 1'b0, 2'd1);
        // R9: the same stray bits are dropped on the direct-mapped path
        for (int b = 44; b < 64; b++)
            apply_check("R9", (64'd1 << b) | 64'h55, 1'b1, 1'b1,
                        64'h55, 1'b0, 2'd0);
        // R10: fetch flag on a cacheable direct-mapped address
        apply_check("R10", 64'h0000_00AB_CDEF_0123, 1'b1, 1'b1,
                    64'h0000_00AB_CDEF_0123, 1'b0, 2'd0);
        // R3: fold boundary, bit 34 and bit 43 kept, bits 42:35 dropped
        apply_check("R3", 64'h0000_0FE4_0000_0000, 1'b0, 1'b0,
                    64'h0000_0804_0000_0000, 1'b1, 2'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got running exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule